// File: doc/BRIEF.md
# Card Host Command and Data Timeout Monitor

This block sits inside a memory-card host controller and watches two phases of every command sequence. The command-response timer starts when a command has finished going out. It counts strobes of the transfer-clock enable and raises a sticky command timeout flag if the response does not complete within the selected window. The data timer counts pulses from a free-running prescaler that divides the peripheral clock. It starts with the command sequence. When the count reaches a programmable limit it raises a data timeout flag, but only while the error interrupt enable is high.

The data timer does not stop at the limit. As long as the sequence stays open, the counter keeps running and wraps, so the error condition comes back every time the count lands on the limit again. Software is expected to end the sequence with the abort strobe and then clear the flag. The interrupt request combines both flags. All pins are plain control and status levels or single-cycle strobes in the peripheral clock domain. There is no streaming data path, so no valid/ready handshake applies.

Top module: `card_timeout_mon`

## Requirements
- R1: After a `cmd_sent` strobe, the command timer counts cycles with `xfer_tick` high. `cmd_to_flag` becomes 1 at the clock edge of the W-th such tick, where W is 128 for `cmd_tsel` = 2'b00 and 256 for `cmd_tsel` = 2'b01.
- R2: A `rsp_done` strobe stops the command timer, and `cmd_to_flag` is then not set. This holds when `rsp_done` arrives before the W-th tick and also when it arrives in the same cycle as the W-th tick. A response that arrives after the W-th tick does not undo the flag.
- R3: `cmd_tsel` values 2'b10 and 2'b11 are reserved. Both give a 256-tick window and drive `cfg_err` to 1. For 2'b00 and 2'b01, `cfg_err` is 0.
- R4: The prescaler runs freely from reset and emits one pulse every `PRESC_DIV` peripheral clocks. Sequence events do not affect it. The pulse is taken at edges N·PRESC_DIV, counted from the first edge after reset release.
- R5: `seq_start` loads the data counter with 0 and makes it active. The counter then adds one per prescaler pulse. The data error condition occurs on the pulse that brings the count equal to the limit.
- R6: `seq_end` or `seq_abort` clears the data counter to 0 and stops it. If either arrives in the same cycle as `seq_start`, it wins. A later `seq_start` counts from 0 again.
- R7: The limit register resets to all ones. It is loaded from `limit_wdata` in a cycle with `limit_wr` high.
- R8: `data_to_flag` is set by a data error condition only while `err_ie` is 1. While `err_ie` is 0, the condition leaves the flag unchanged.
- R9: While the sequence stays active, the counter wraps from all ones to 0 and keeps going. The error condition recurs 2^LIM_W pulses after each match.
- R10: A limit of 0 acts like a limit of 1. The error condition occurs on the first prescaler pulse after `seq_start`.
- R11: Both flags are sticky. `cmd_to_flag` is cleared only by `cmd_clr`, and `data_to_flag` only by `data_clr`. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R12: `irq` is 1 exactly when at least one of `cmd_to_flag` and `data_to_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_tick | input | 1 | Transfer-clock enable strobe, one per transfer cycle |
| cmd_sent | input | 1 | Command transmission finished |
| rsp_done | input | 1 | Response reception finished |
| cmd_tsel | input | 2 | Command window select: 00 gives 128, 01 gives 256, 1x is reserved |
| seq_start | input | 1 | Command sequence begins |
| seq_end | input | 1 | Command sequence completed |
| seq_abort | input | 1 | Command sequence aborted by software |
| limit_wr | input | 1 | Load strobe for the data limit register |
| limit_wdata | input | LIM_W | New data limit value |
| err_ie | input | 1 | Data timeout error enable |
| cmd_clr | input | 1 | Clear strobe for the command timeout flag |
| data_clr | input | 1 | Clear strobe for the data timeout flag |
| cmd_to_flag | output | 1 | Sticky command timeout flag |
| data_to_flag | output | 1 | Sticky data timeout flag |
| irq | output | 1 | Interrupt request, OR of both flags |
| cfg_err | output | 1 | Reserved command window select in use |

## Verification
Two collisions can happen in a single cycle. The first is a flag being set and the same flag being cleared. The second is a response arriving on the very tick that ends the command window. The bench provokes the first by tracking the prescaler phase from reset release. It raises `data_clr` for exactly the cycle whose edge carries the matching pulse, then expects `data_to_flag` to read 1 afterwards. The second is a row of the command vector table where `rsp_done` coincides with the 128th tick. That row must leave the flag clear, while the neighbouring row, with the response one tick later, must leave it set.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  localparam int unsigned CMD_WIN_SHORT = 128;
  localparam int unsigned CMD_WIN_LONG  = 256;
  localparam int unsigned PRESC_DEFAULT = 10000;
  localparam int unsigned LIM_W_DEFAULT = 16;

  typedef enum logic [1:0] {
    TSEL_SHORT = 2'b00,
    TSEL_LONG  = 2'b01,
    TSEL_RSV2  = 2'b10,
    TSEL_RSV3  = 2'b11
  } tsel_e;
endpackage

// File: rtl/ctm_prescaler.sv
module ctm_prescaler #(
  parameter int unsigned DIV = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic pulse
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  assign pulse = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (pulse) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // R4: after each pulse the divider restarts from zero
  assert_presc_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> (cnt_q == '0));
endmodule

// File: rtl/ctm_cmd_timer.sv
module ctm_cmd_timer
  import ctm_pkg::*;
#(
  parameter int unsigned WIN_SHORT = CMD_WIN_SHORT,
  parameter int unsigned WIN_LONG  = CMD_WIN_LONG
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic       stop,
  input  logic [1:0] tsel,
  input  logic       clr,
  output logic       flag,
  output logic       cfg_err
);
  localparam int unsigned CW = $clog2(WIN_LONG + 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic [CW-1:0] window;
  logic          expire;

  always_comb begin
    unique case (tsel_e'(tsel))
      TSEL_SHORT: window = CW'(WIN_SHORT);
      default:    window = CW'(WIN_LONG);
    endcase
  end

  assign cfg_err = tsel[1];
  assign cnt_nxt = cnt_q + 1'b1;
  assign expire  = run_q && !start && !stop && tick && (cnt_nxt == window);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (stop || expire) run_q <= 1'b0;
      else if (tick)      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      flag <= 1'b0;
    else if (expire) flag <= 1'b1;
    else if (clr)    flag <= 1'b0;
  end

  // R2: with the timer idle, the flag cannot appear
  assert_cmd_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !flag) |=> !flag);
  // R11: the flag holds until its own clear strobe
  assert_cmd_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R1: the count never passes the largest window
  assert_cmd_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < CW'(WIN_LONG)));
endmodule

// File: rtl/ctm_data_timer.sv
module ctm_data_timer #(
  parameter int unsigned LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse,
  input  logic             start,
  input  logic             stop,
  input  logic [LIM_W-1:0] limit,
  input  logic             ie,
  input  logic             clr,
  output logic             flag
);
  logic             active_q;
  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] cnt_nxt;
  logic [LIM_W-1:0] eff_limit;
  logic             hit;

  assign eff_limit = (limit == '0) ? LIM_W'(1) : limit;
  assign cnt_nxt   = cnt_q + 1'b1;
  assign hit       = active_q && !stop && !start && pulse && (cnt_nxt == eff_limit);

  always_ff @(posedge clk) begin
    if (!rst_n || stop) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && pulse) begin
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          flag <= 1'b0;
    else if (hit && ie)  flag <= 1'b1;
    else if (clr)        flag <= 1'b0;
  end

  // R6: an end or abort leaves the counter cleared and stopped
  assert_data_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!active_q && cnt_q == '0));
  // R5: an idle counter stays at zero until a start
  assert_data_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !start) |=> (cnt_q == '0));
  // R8: with the enable low, the flag cannot appear
  assert_data_ie_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie && !flag) |=> !flag);
  // R11: the flag holds until its own clear strobe
  assert_data_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/card_timeout_mon.sv
module card_timeout_mon
  import ctm_pkg::*;
#(
  parameter int unsigned PRESC_DIV = PRESC_DEFAULT,
  parameter int unsigned LIM_W     = LIM_W_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_tick,
  input  logic             cmd_sent,
  input  logic             rsp_done,
  input  logic [1:0]       cmd_tsel,
  input  logic             seq_start,
  input  logic             seq_end,
  input  logic             seq_abort,
  input  logic             limit_wr,
  input  logic [LIM_W-1:0] limit_wdata,
  input  logic             err_ie,
  input  logic             cmd_clr,
  input  logic             data_clr,
  output logic             cmd_to_flag,
  output logic             data_to_flag,
  output logic             irq,
  output logic             cfg_err
);
  logic             presc_pulse;
  logic [LIM_W-1:0] limit_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        limit_q <= '1;
    else if (limit_wr) limit_q <= limit_wdata;
  end

  ctm_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .pulse (presc_pulse)
  );

  ctm_cmd_timer u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (xfer_tick),
    .start   (cmd_sent),
    .stop    (rsp_done),
    .tsel    (cmd_tsel),
    .clr     (cmd_clr),
    .flag    (cmd_to_flag),
    .cfg_err (cfg_err)
  );

  ctm_data_timer #(.LIM_W(LIM_W)) u_data (
    .clk   (clk),
    .rst_n (rst_n),
    .pulse (presc_pulse),
    .start (seq_start),
    .stop  (seq_end | seq_abort),
    .limit (limit_q),
    .ie    (err_ie),
    .clr   (data_clr),
    .flag  (data_to_flag)
  );

  assign irq = cmd_to_flag | data_to_flag;

  // R7: the limit register takes the written value one edge later
  assert_limit_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    limit_wr |=> (limit_q == $past(limit_wdata)));
  // R12: any raised flag reaches the request line
  assert_irq_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_to_flag) || $rose(data_to_flag)) |-> irq);
endmodule

// File: tb/card_timeout_mon_tb.sv
module card_timeout_mon_tb;
  localparam int DIV = 20;
  localparam int LW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          xfer_tick = 0, cmd_sent = 0, rsp_done = 0;
  logic [1:0]    cmd_tsel = 2'b00;
  logic          seq_start = 0, seq_end = 0, seq_abort = 0;
  logic          limit_wr = 0;
  logic [LW-1:0] limit_wdata = '0;
  logic          err_ie = 0, cmd_clr = 0, data_clr = 0;
  logic          cmd_to_flag, data_to_flag, irq, cfg_err;

  int checks = 0;
  int errors = 0;
  int ncyc   = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ncyc <= 0;
    else        ncyc <= ncyc + 1;
  end

  card_timeout_mon #(.PRESC_DIV(DIV), .LIM_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_tick(xfer_tick), .cmd_sent(cmd_sent),
    .rsp_done(rsp_done), .cmd_tsel(cmd_tsel), .seq_start(seq_start),
    .seq_end(seq_end), .seq_abort(seq_abort), .limit_wr(limit_wr),
    .limit_wdata(limit_wdata), .err_ie(err_ie), .cmd_clr(cmd_clr),
    .data_clr(data_clr), .cmd_to_flag(cmd_to_flag), .data_to_flag(data_to_flag),
    .irq(irq), .cfg_err(cfg_err)
  );

  // {tsel[1:0], rsp_tick[9:0] (0 = none), probe_tick[9:0], exp_probe, exp_final, exp_cfg}
  localparam logic [24:0] CMD_VEC [9] = '{
    {2'b00, 10'd0,   10'd127, 1'b0, 1'b1, 1'b0},
    {2'b00, 10'd0,   10'd128, 1'b1, 1'b1, 1'b0},
    {2'b00, 10'd128, 10'd128, 1'b0, 1'b0, 1'b0},
    {2'b00, 10'd129, 10'd128, 1'b1, 1'b1, 1'b0},
    {2'b01, 10'd0,   10'd255, 1'b0, 1'b1, 1'b0},
    {2'b01, 10'd200, 10'd256, 1'b0, 1'b0, 1'b0},
    {2'b10, 10'd0,   10'd256, 1'b1, 1'b1, 1'b1},
    {2'b11, 10'd0,   10'd255, 1'b0, 1'b1, 1'b1},
    {2'b00, 10'd60,  10'd200, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b (cycle %0d)", req, act, exp, ncyc);
    end
  endtask

  task automatic to_mid();
    do @(negedge clk); while ((ncyc % DIV) != DIV / 2);
  endtask

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) to_mid();
  endtask

  task automatic start_seq();
    to_mid();
    seq_start = 1'b1;
    @(negedge clk);
    seq_start = 1'b0;
  endtask

  task automatic stop_seq(input logic use_abort);
    if (use_abort) seq_abort = 1'b1; else seq_end = 1'b1;
    @(negedge clk);
    seq_abort = 1'b0;
    seq_end   = 1'b0;
  endtask

  task automatic write_limit(input logic [LW-1:0] v);
    limit_wdata = v;
    limit_wr    = 1'b1;
    @(negedge clk);
    limit_wr = 1'b0;
  endtask

  task automatic clear_data();
    data_clr = 1'b1;
    @(negedge clk);
    data_clr = 1'b0;
  endtask

  task automatic clear_cmd();
    cmd_clr = 1'b1;
    @(negedge clk);
    cmd_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset cmd flag", cmd_to_flag, 1'b0);
    check("R11 reset data flag", data_to_flag, 1'b0);
    check("R12 reset irq", irq, 1'b0);
    rst_n = 1'b1;

    // Command timer vector walk: R1 R2 R3
    foreach (CMD_VEC[v]) begin
      cmd_tsel = CMD_VEC[v][24:23];
      @(negedge clk);
      cmd_sent = 1'b1;
      @(negedge clk);
      cmd_sent = 1'b0;
      for (int t = 1; t <= 300; t++) begin
        xfer_tick = 1'b1;
        rsp_done  = (t == int'(CMD_VEC[v][22:13]));
        @(negedge clk);
        if (t == int'(CMD_VEC[v][12:3]))
          check($sformatf("R1/R2 vec%0d probe", v), cmd_to_flag, CMD_VEC[v][2]);
      end
      xfer_tick = 1'b0;
      rsp_done  = 1'b0;
      check($sformatf("R1/R2 vec%0d final", v), cmd_to_flag, CMD_VEC[v][1]);
      check($sformatf("R3 vec%0d cfg_err", v), cfg_err, CMD_VEC[v][0]);
      if (CMD_VEC[v][1]) check("R12 irq from cmd flag", irq, 1'b1);
      clear_cmd();
      check("R11 cmd clear", cmd_to_flag, 1'b0);
    end
    cmd_tsel = 2'b00;

    // R7 reset limit is all ones: no error at 254 pulses, error at 255
    err_ie = 1'b1;
    start_seq();
    pulses(254);
    check("R7 default limit before", data_to_flag, 1'b0);
    pulses(1);
    check("R7 default limit reached", data_to_flag, 1'b1);
    check("R12 irq from data flag", irq, 1'b1);
    stop_seq(1'b1);
    clear_data();
    check("R11 data clear", data_to_flag, 1'b0);

    // R5 R9: limit 3, match then recurrence after wrap
    write_limit(8'd3);
    start_seq();
    pulses(2);
    check("R5 before limit", data_to_flag, 1'b0);
    pulses(1);
    check("R5 at limit", data_to_flag, 1'b1);
    clear_data();
    pulses(255);
    check("R9 no recurrence before wrap", data_to_flag, 1'b0);
    pulses(1);
    check("R9 recurrence after wrap", data_to_flag, 1'b1);
    stop_seq(1'b0);
    clear_data();

    // R4 R6 abort mid-count, restart counts from zero
    start_seq();
    pulses(2);
    stop_seq(1'b1);
    pulses(3);
    check("R6 stopped after abort", data_to_flag, 1'b0);
    start_seq();
    pulses(2);
    check("R6 restart from zero", data_to_flag, 1'b0);
    pulses(1);
    check("R4/R6 restart reaches limit", data_to_flag, 1'b1);
    stop_seq(1'b0);
    clear_data();

    // R6 end strobe also stops
    start_seq();
    pulses(2);
    stop_seq(1'b0);
    pulses(2);
    check("R6 stopped after end", data_to_flag, 1'b0);

    // R8 enable low: the match leaves the flag clear
    err_ie = 1'b0;
    write_limit(8'd2);
    start_seq();
    pulses(3);
    check("R8 gated by enable", data_to_flag, 1'b0);
    check("R12 irq quiet", irq, 1'b0);
    stop_seq(1'b1);
    err_ie = 1'b1;

    // R10 limit zero fires on first pulse
    write_limit(8'd0);
    start_seq();
    check("R10 none before pulse", data_to_flag, 1'b0);
    pulses(1);
    check("R10 first pulse", data_to_flag, 1'b1);
    stop_seq(1'b1);
    clear_data();

    // R11 set and clear in the same cycle: set wins
    write_limit(8'd1);
    start_seq();
    while (((ncyc + 1) % DIV) != 0) @(negedge clk);
    data_clr = 1'b1;
    @(negedge clk);
    data_clr = 1'b0;
    check("R11 set beats clear", data_to_flag, 1'b1);
    stop_seq(1'b1);
    clear_data();
    check("R11 clear after collision", data_to_flag, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule